// File: doc/BRIEF.md
# Ternary Content-Addressable Memory with Mask Register

This block is a ternary content-addressable memory. One shared data bus serves two operations. A write stores the bus value into an addressed entry, the way a RAM write does. A compare looks for the bus value in every entry at the same time. Every stored bit has a care state. A bit that is not cared about matches either key value, so each entry can hold wildcard bits. The write-don't-care input sets up these wildcard bits.

A mask register is loaded through its own strobe. When the mask-enable input is high, mask bits set to 1 do two things. They protect the matching entry bits from being changed by a write. They also remove those bit positions from the compare. The outputs are a hit flag, a multiple-hit flag and the lowest matching entry index. A build-time option selects whether these outputs are registered or combinational. All state shares one clock and one clock enable. The reset is the OR of a global reset and a local reset.

Top module: `tern_cam`

## Requirements
- R1: When wr_en and wr_cs are both 1 and ce is 1 at a rising clock edge, the entry at wr_addr takes the value of wd_key and becomes valid. If either wr_en or wr_cs is 0, nothing is written.
- R2: hit is 1 when at least one valid entry matches the key. hit_addr then gives the lowest matching entry index.
- R3: hit_multi is 1 when two or more entries match. hit_multi is never 1 while hit is 0.
- R4: When no entry matches, hit_addr is 0 and both flags are 0. After reset every entry is invalid and matches nothing.
- R5: During a write with mask_en = 1, every bit position whose mask bit is 1 keeps its previous stored value and its previous care state.
- R6: During a compare with mask_en = 1, bit positions whose mask bit is 1 are left out of the comparison.
- R7: A write with wr_dc = 1 stores every unmasked bit as don't-care, and such a bit matches both key values. A write with wr_dc = 0 stores every unmasked bit as cared.
- R8: mask_ld = 1 with ce = 1 loads mask_din into the mask register at the clock edge. A write or compare in the same cycle uses the mask value held before that edge.
- R9: A compare made in the same cycle as a write sees the array contents as they were before that write.
- R10: With OUT_MODE = OUT_REG, the outputs update at each edge where ce = 1, carrying the compare result of that cycle's inputs. With OUT_MODE = OUT_COMB, the outputs follow the inputs in the same cycle.
- R11: While ce is 0, no entry is written, the mask register is not loaded, and the registered outputs hold their values.
- R12: rst_global = 1 or rst_local = 1 at a clock edge does four things, whatever the value of ce. It invalidates every entry, clears the mask register to all zeros, resets the stored bits to 0 with care state set, and clears the registered outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ce | input | 1 | Clock enable for all registers |
| rst_global | input | 1 | Global synchronous reset, active high |
| rst_local | input | 1 | Local synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_cs | input | 1 | Write chip select |
| wr_dc | input | 1 | Write unmasked bits as don't-care |
| wr_addr | input | AW | Entry index for writes |
| wd_key | input | WIDTH | Write data, and the compare key |
| mask_en | input | 1 | Apply the mask register to this cycle's operation |
| mask_ld | input | 1 | Load strobe for the mask register |
| mask_din | input | WIDTH | New mask register value |
| hit_addr | output | AW | Lowest matching entry index, 0 on a miss |
| hit | output | 1 | At least one entry matches |
| hit_multi | output | 1 | Two or more entries match |

## Verification
Two events can fall in the same cycle: a mask-register load, and a masked write or masked compare. The bench provokes this directly. It loads a new mask in the same cycle as a masked write. It then compares keys that agree with only one of the two mask values, which shows whether the write used the old mask or the new one. The bench also places a compare in the same cycle as a write to the entry it looks for. A reference model computes the expected results and judges both cases. Both output variants are checked: the registered outputs one edge later, the combinational ones within the cycle.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
   typedef enum logic {
      OUT_COMB = 1'b0,
      OUT_REG  = 1'b1
   } tcam_out_e;
endpackage

// File: rtl/tcam_mask_reg.sv
module tcam_mask_reg #(
   parameter int WIDTH = 48
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ce,
   input  logic             ld,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] mask_q
);
   always_ff @(posedge clk) begin
      if (rst)          mask_q <= '0;
      else if (ce && ld) mask_q <= din;
   end

   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
      (ce && ld) |=> (mask_q == $past(din)));           // R8
   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(ce && ld) |=> $stable(mask_q));                 // R11
endmodule

// File: rtl/tcam_store.sv
module tcam_store #(
   parameter int ENTRIES = 128,
   parameter int WIDTH   = 48,
   parameter int AW      = 7
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               ce,
   input  logic               wr_fire,
   input  logic [AW-1:0]      wr_addr,
   input  logic [WIDTH-1:0]   wr_data,
   input  logic               wr_dc,
   input  logic               mask_en,
   input  logic [WIDTH-1:0]   mask_q,
   input  logic [WIDTH-1:0]   key,
   output logic [ENTRIES-1:0] hits
);
   logic [WIDTH-1:0]   data_q [ENTRIES];
   logic [WIDTH-1:0]   care_q [ENTRIES];
   logic [ENTRIES-1:0] valid_q;
   logic [WIDTH-1:0]   keep;      // bits protected from this write
   logic [WIDTH-1:0]   ign;       // bits left out of this compare

   assign keep = mask_en ? mask_q : '0;
   assign ign  = keep;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= '0;
         for (int e = 0; e < ENTRIES; e++) begin
            data_q[e] <= '0;
            care_q[e] <= '1;
         end
      end else if (ce && wr_fire) begin
         data_q[wr_addr]  <= (data_q[wr_addr] & keep) | (wr_data & ~keep);
         care_q[wr_addr]  <= (care_q[wr_addr] & keep) | ({WIDTH{~wr_dc}} & ~keep);
         valid_q[wr_addr] <= 1'b1;
      end
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign hits[e] = valid_q[e] & (&((data_q[e] ~^ key) | ~care_q[e] | ign));
   end

   AST_WRITE_VALID: assert property (@(posedge clk) disable iff (rst)
      (ce && wr_fire) |=> valid_q[$past(wr_addr)]);                       // R1
   AST_WRITE_DATA: assert property (@(posedge clk) disable iff (rst)
      (ce && wr_fire && !mask_en) |=> (data_q[$past(wr_addr)] == $past(wr_data))); // R1
   AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
      (ce && wr_fire && mask_en) |=>
      (((data_q[$past(wr_addr)] ^ $past(data_q[wr_addr])) & $past(mask_q)) == '0)); // R5
endmodule

// File: rtl/tcam_prio.sv
module tcam_prio #(
   parameter int ENTRIES = 128,
   parameter int AW      = 7
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [ENTRIES-1:0] hits,
   output logic               found,
   output logic               multi,
   output logic [AW-1:0]      addr
);
   localparam logic [ENTRIES-1:0] ONE = {{(ENTRIES-1){1'b0}}, 1'b1};
   logic [ENTRIES-1:0] below;

   always_comb begin
      addr  = '0;
      found = 1'b0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (hits[e]) begin
            addr  = AW'(e);
            found = 1'b1;
         end
      end
   end

   assign multi = |(hits & (hits - ONE));
   assign below = (ONE << addr) - ONE;

   AST_LOWEST_HIT: assert property (@(posedge clk) disable iff (rst)
      found |-> (hits[addr] && ((hits & below) == '0)));   // R2
   AST_MULTI_COUNT: assert property (@(posedge clk) disable iff (rst)
      multi |-> ($countones(hits) > 1));                    // R3
endmodule

// File: rtl/tern_cam.sv
module tern_cam
   import tcam_pkg::*;
#(
   parameter int        ENTRIES  = 128,
   parameter int        WIDTH    = 48,
   parameter int        AW       = $clog2(ENTRIES),
   parameter tcam_out_e OUT_MODE = OUT_REG
) (
   input  logic             clk,
   input  logic             ce,
   input  logic             rst_global,
   input  logic             rst_local,
   input  logic             wr_en,
   input  logic             wr_cs,
   input  logic             wr_dc,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wd_key,
   input  logic             mask_en,
   input  logic             mask_ld,
   input  logic [WIDTH-1:0] mask_din,
   output logic [AW-1:0]    hit_addr,
   output logic             hit,
   output logic             hit_multi
);
   if (ENTRIES < 2) begin : g_bad_entries
      $error("tern_cam: ENTRIES must be at least 2");
   end
   if (AW != $clog2(ENTRIES) || (1 << AW) != ENTRIES) begin : g_bad_aw
      $error("tern_cam: ENTRIES must be a power of two and AW its log2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("tern_cam: WIDTH must be positive");
   end

   logic               rst;
   logic               wr_fire;
   logic [WIDTH-1:0]   mask_q;
   logic [ENTRIES-1:0] hits;
   logic               c_found, c_multi;
   logic [AW-1:0]      c_addr;

   assign rst     = rst_global | rst_local;
   assign wr_fire = wr_en & wr_cs;

   tcam_mask_reg #(.WIDTH(WIDTH)) u_mask (
      .clk(clk), .rst(rst), .ce(ce), .ld(mask_ld), .din(mask_din), .mask_q(mask_q)
   );

   tcam_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .AW(AW)) u_store (
      .clk(clk), .rst(rst), .ce(ce), .wr_fire(wr_fire), .wr_addr(wr_addr),
      .wr_data(wd_key), .wr_dc(wr_dc), .mask_en(mask_en), .mask_q(mask_q),
      .key(wd_key), .hits(hits)
   );

   tcam_prio #(.ENTRIES(ENTRIES), .AW(AW)) u_prio (
      .clk(clk), .rst(rst), .hits(hits),
      .found(c_found), .multi(c_multi), .addr(c_addr)
   );

   if (OUT_MODE == OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            hit       <= 1'b0;
            hit_multi <= 1'b0;
            hit_addr  <= '0;
         end else if (ce) begin
            hit       <= c_found;
            hit_multi <= c_multi;
            hit_addr  <= c_addr;
         end
      end
      AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
         !ce |=> $stable({hit, hit_multi, hit_addr}));            // R11
      AST_OUT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
         ce |=> (hit == $past(c_found)));                          // R10
   end else begin : g_comb
      assign hit       = c_found;
      assign hit_multi = c_multi;
      assign hit_addr  = c_addr;
   end

   AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
      hit_multi |-> hit);                                          // R3
   AST_MISS_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
      !hit |-> (hit_addr == '0));                                  // R4
endmodule

// File: tb/tern_cam_tb_top.sv
`timescale 1ns/1ps
module tern_cam_tb_top;
   import tcam_pkg::*;
   localparam int N = 128;
   localparam int W = 48;
   localparam int A = 7;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic ce, rg, rl, we, cs, dc, men, mld;
   logic [A-1:0] wa;
   logic [W-1:0] wd, md;
   logic [A-1:0] r_addr, c_addr;
   logic r_hit, r_multi, c_hit, c_multi;

   tern_cam #(.ENTRIES(N), .WIDTH(W), .OUT_MODE(OUT_REG)) dut_i (
      .clk(clk), .ce(ce), .rst_global(rg), .rst_local(rl), .wr_en(we), .wr_cs(cs),
      .wr_dc(dc), .wr_addr(wa), .wd_key(wd), .mask_en(men), .mask_ld(mld),
      .mask_din(md), .hit_addr(r_addr), .hit(r_hit), .hit_multi(r_multi));
   tern_cam #(.ENTRIES(N), .WIDTH(W), .OUT_MODE(OUT_COMB)) dut_c (
      .clk(clk), .ce(ce), .rst_global(rg), .rst_local(rl), .wr_en(we), .wr_cs(cs),
      .wr_dc(dc), .wr_addr(wa), .wd_key(wd), .mask_en(men), .mask_ld(mld),
      .mask_din(md), .hit_addr(c_addr), .hit(c_hit), .hit_multi(c_multi));

   // reference model
   logic [W-1:0] m_data [N];
   logic [W-1:0] m_care [N];
   logic [N-1:0] m_val;
   logic [W-1:0] m_mask;
   logic         x_hit, x_multi, q_hit, q_multi;
   logic [A-1:0] x_addr, q_addr;
   int checks = 0, fails = 0;
   bit done = 0;

   task automatic model_reset();
      for (int e = 0; e < N; e++) begin m_data[e] = '0; m_care[e] = '1; end
      m_val = '0; m_mask = '0;
   endtask

   task automatic model_cmp(input logic [W-1:0] key, input logic use_mask);
      logic [W-1:0] ign;
      int cnt;
      ign = use_mask ? m_mask : '0;
      cnt = 0; x_addr = '0;
      for (int e = N - 1; e >= 0; e--) begin
         if (m_val[e] && ((~(m_data[e] ^ key) | ~m_care[e] | ign) == '1)) begin
            cnt++; x_addr = A'(e);
         end
      end
      x_hit = (cnt > 0); x_multi = (cnt > 1);
   endtask

   task automatic check(input string tag, input string who, input logic h, input logic mm,
                        input logic [A-1:0] a, input logic eh, input logic emm,
                        input logic [A-1:0] ea);
      checks++;
      if ({h, mm, a} !== {eh, emm, ea}) begin
         fails++;
         $display("FAIL %s %s: got hit=%0b multi=%0b addr=%0d exp hit=%0b multi=%0b addr=%0d",
                  tag, who, h, mm, a, eh, emm, ea);
      end
   endtask

   task automatic cyc(input string tag, input logic i_we, input logic i_cs, input logic i_dc,
                      input logic i_men, input logic i_mld, input logic i_ce,
                      input logic i_rg, input logic i_rl, input logic [A-1:0] i_a,
                      input logic [W-1:0] i_d, input logic [W-1:0] i_md);
      logic [W-1:0] keep;
      @(negedge clk);
      we = i_we; cs = i_cs; dc = i_dc; men = i_men; mld = i_mld; ce = i_ce;
      rg = i_rg; rl = i_rl; wa = i_a; wd = i_d; md = i_md;
      #1;
      model_cmp(i_d, i_men);
      check(tag, "comb", c_hit, c_multi, c_addr, x_hit, x_multi, x_addr);
      @(posedge clk);
      #1;
      if (i_rg || i_rl) begin
         model_reset();
         q_hit = 0; q_multi = 0; q_addr = '0;
      end else if (i_ce) begin
         q_hit = x_hit; q_multi = x_multi; q_addr = x_addr;
         if (i_we && i_cs) begin
            keep = i_men ? m_mask : '0;
            m_data[i_a] = (m_data[i_a] & keep) | (i_d & ~keep);
            m_care[i_a] = (m_care[i_a] & keep) | ({W{~i_dc}} & ~keep);
            m_val[i_a]  = 1'b1;
         end
         if (i_mld) m_mask = i_md;
      end
      check(tag, "reg", r_hit, r_multi, r_addr, q_hit, q_multi, q_addr);
   endtask

   // shorthands
   task automatic wr(input string tag, input logic [A-1:0] a, input logic [W-1:0] d,
                     input logic i_dc, input logic i_men);
      cyc(tag, 1, 1, i_dc, i_men, 0, 1, 0, 0, a, d, '0);
   endtask
   task automatic cmp(input string tag, input logic [W-1:0] k, input logic i_men);
      cyc(tag, 0, 0, 0, i_men, 0, 1, 0, 0, '0, k, '0);
   endtask

   function automatic logic [W-1:0] rnd48();
      return {$urandom, $urandom} & {W{1'b1}};
   endfunction

   initial begin
      #(200000 * 5.0);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] ka, kb, kc, ke, pool [4];
      void'($urandom(32'd20240611));
      {ce, rg, rl, we, cs, dc, men, mld} = '0;
      wa = '0; wd = '0; md = '0;
      model_reset();
      q_hit = 0; q_multi = 0; q_addr = '0;
      ka = 48'h0123_4567_89AB; kb = 48'hFEDC_BA98_7654; kc = 48'h5A5A_0F0F_3C3C;
      ke = 48'h1111_2222_33CC;

      // R12 reset, R4 empty array
      cyc("R12", 0, 0, 0, 0, 0, 1, 1, 0, '0, '0, '0);
      cyc("R12", 0, 0, 0, 0, 0, 0, 1, 0, '0, '0, '0);
      cmp("R4", ka, 0);
      // R1 writes, R2/R3 lowest and multiple
      wr("R1", 7'd9, ka, 0, 0);
      wr("R1", 7'd5, ka, 0, 0);
      cmp("R2", ka, 0);
      cmp("R3", ka, 0);
      cmp("R4", kb, 0);
      // R1 no write without chip select / enable
      cyc("R1", 1, 0, 0, 0, 0, 1, 0, 0, 7'd3, kb, '0);
      cyc("R1", 0, 1, 0, 0, 0, 1, 0, 0, 7'd3, kb, '0);
      cmp("R1", kb, 0);
      // R11 ce low: no write, no mask load, outputs hold
      cmp("R11", ka, 0);
      cyc("R11", 1, 1, 0, 0, 1, 0, 0, 0, 7'd2, kb, 48'hFF);
      cyc("R11", 0, 0, 0, 0, 0, 0, 0, 0, '0, kc, '0);
      cmp("R11", kb, 0);
      cmp("R11", ka ^ 48'h1, 1);
      // R7 don't-care entry matches anything
      wr("R7", 7'd7, kc, 1, 0);
      cmp("R7", kc, 0);
      cmp("R7", kb, 0);
      cmp("R7", ka, 0);
      wr("R7", 7'd7, kc, 0, 0);
      cmp("R7", kb, 0);
      // R8 mask load coinciding with masked write uses old (zero) mask
      cyc("R8", 1, 1, 0, 1, 1, 1, 0, 0, 7'd20, kb, 48'h0000_0000_00FF);
      cmp("R8", kb, 0);
      // R5 masked write keeps low byte
      wr("R5", 7'd20, ke, 0, 1);
      cmp("R5", {ke[47:8], kb[7:0]}, 0);
      cmp("R5", ke, 0);
      // R5/R7 masked don't-care write: only unmasked bits become wildcards
      wr("R7", 7'd21, kc, 0, 0);
      wr("R7", 7'd21, '0, 1, 1);
      cmp("R7", {rnd48() >> 8, kc[7:0]}, 0);
      cmp("R7", {kb[47:8], kc[7:0] ^ 8'h01}, 0);
      // R6 compare mask
      cmp("R6", {ka[47:8], ~ka[7:0]}, 1);
      cmp("R6", {ka[47:8], ~ka[7:0]}, 0);
      // R8 new mask applies only after its load edge
      cyc("R8", 0, 0, 0, 1, 1, 1, 0, 0, '0, {ka[47:16], ~ka[15:8], ka[7:0]}, 48'h0000_0000_FF00);
      cmp("R8", {ka[47:16], ~ka[15:8], ka[7:0]}, 1);
      // R9 compare in the write cycle sees old contents
      wr("R9", 7'd0, 48'hABCD_EF01_2345, 0, 0);
      cmp("R9", 48'hABCD_EF01_2345, 0);
      // R12 each reset source alone
      cyc("R12", 0, 0, 0, 0, 0, 1, 0, 1, '0, '0, '0);
      cmp("R12", ka, 0);
      wr("R12", 7'd1, ka, 0, 0);
      cyc("R12", 0, 0, 0, 0, 0, 0, 1, 0, '0, '0, '0);
      cmp("R12", ka, 1);

      // R10 random traffic on both output variants
      for (int p = 0; p < 4; p++) pool[p] = rnd48();
      for (int i = 0; i < 4000; i++) begin
         logic [W-1:0] d;
         int op;
         op = $urandom % 100;
         d = pool[$urandom % 4];
         if ($urandom % 3 == 0) d = d ^ (48'h1 << ($urandom % 48));
         if (op < 30)
            cyc("R10", 1, ($urandom % 8) != 0, ($urandom % 6) == 0, $urandom % 2,
                ($urandom % 10) == 0, ($urandom % 10) != 0, 0, 0,
                A'($urandom % 24), d, rnd48() & 48'h0000_FFFF_00FF);
         else if (op < 99)
            cyc("R10", 0, 0, 0, $urandom % 2, ($urandom % 20) == 0,
                ($urandom % 10) != 0, 0, 0, '0, d, rnd48() & 48'hFF00_0000_FF00);
         else
            cyc("R12", 0, 0, 0, 0, 0, $urandom % 2, $urandom % 2, 1, '0, '0, '0);
      end

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule